// File: doc/BRIEF.md
# PAUSE Frame Transmit Sequencer

This block turns a software request for a flow-control PAUSE frame into a controlled transmit sequence. When a request arrives and the link runs full duplex, the block raises a graceful-stop request toward the data transmitter. It then waits until the transmitter reports that ordinary data traffic has drained, and gives one interrupt pulse to mark the stop. After that it streams the 18 header bytes of the PAUSE frame through a byte handshake.

The header holds the reserved multicast destination 01-80-C2-00-00-01, the station's own source address, the MAC control type 0x8808, the PAUSE opcode 0x0001 and the programmed 16-bit pause duration. Once the downstream logic has taken the last byte, the block drops its stop request and clears the software request bit in the same cycle. Preamble, padding and frame check sequence are added further down the transmit path.

Top module: `pause_tx_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, gstop_req_o, stop_irq_o, tx_valid_o, tx_sof_o, tx_eof_o and req_clr_o are all 0.
- R2: A request (pause_req_i=1) seen at a clock edge while idle with fdx_en_i=1 sets gstop_req_o to 1 from the next cycle onward. With fdx_en_i=0 the request does nothing: gstop_req_o and tx_valid_o stay 0.
- R3: While the block waits for the stop, tx_valid_o stays 0. When stop_done_i is sampled high, stop_irq_o is 1 for exactly the following cycle. The first header byte becomes valid in the cycle after that pulse.
- R4: The header bytes appear in this order, each field most significant byte first: 01 80 C2 00 00 01, then station_addr_i[47:0], then 88 08, then 00 01, then pause_dur_i[15:0].
- R5: tx_sof_o is 1 only while byte 0 is presented and tx_eof_o is 1 only while byte 17 is presented. Both are 0 whenever tx_valid_o is 0.
- R6: A byte is taken at a clock edge where both tx_valid_o and byte_rdy_i are 1. While byte_rdy_i is 0, tx_byte_o, tx_sof_o and tx_eof_o hold their values and tx_valid_o stays 1.
- R7: In the cycle after the last byte is taken, gstop_req_o is 0 and req_clr_o is 1. req_clr_o lasts one cycle, and the block is then idle.
- R8: Dropping or raising pause_req_i while a sequence is in progress has no effect. The block sends exactly one frame, and its byte order is unchanged.
- R9: The source address and duration are captured when the request is accepted. Changes to station_addr_i or pause_dur_i later in the sequence do not alter the bytes sent.
- R10: stop_done_i while idle causes no stop_irq_o pulse and no byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pause_req_i | input | 1 | Software request to send a PAUSE frame |
| fdx_en_i | input | 1 | Full-duplex mode enabled |
| stop_done_i | input | 1 | Transmitter reports data traffic has stopped |
| pause_dur_i | input | 16 | Programmed pause duration |
| station_addr_i | input | 48 | Station source address |
| byte_rdy_i | input | 1 | Downstream ready to take the current byte |
| gstop_req_o | output | 1 | Graceful-stop request to the data transmitter |
| stop_irq_o | output | 1 | One-cycle stop-complete interrupt pulse |
| tx_byte_o | output | 8 | Header byte being offered |
| tx_valid_o | output | 1 | tx_byte_o is valid |
| tx_sof_o | output | 1 | First byte of the frame |
| tx_eof_o | output | 1 | Last byte of the frame |
| req_clr_o | output | 1 | One-cycle pulse that clears the request bit |

## Verification
The bench targets four kinds of error. The first is a frame that starts before the stop is confirmed: a design that skipped the wait would show valid bytes while stop_done_i is still low. The second is a stalled handshake: a design that advanced on valid alone would skip or repeat bytes, so the bench compares the stream against its own header model under both back-to-back and stalled ready patterns. The third is the end of the frame: the bench checks that the stop request and the request bit drop together, one cycle after the last byte, rather than one cycle early or late. The fourth covers inputs that must be ignored — a request without full duplex, request toggles mid-frame, and address or duration changes after acceptance. A design that wrongly responded would restart, corrupt the frame or never begin.

// File: rtl/pause_seq_pkg.sv
package pause_seq_pkg;

  localparam int ADDR_W = 48;
  localparam int WORD_W = 16;
  localparam int HDR_W  = 2*ADDR_W + 3*WORD_W;
  localparam int HDR_BYTES = HDR_W / 8;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_WAIT,
    PS_ANNOUNCE,
    PS_SEND,
    PS_DONE
  } pause_state_t;

  // Header byte at position idx, fields MSB first.
  function automatic logic [7:0] hdr_byte(
    input int unsigned        idx,
    input logic [ADDR_W-1:0]  da,
    input logic [ADDR_W-1:0]  sa,
    input logic [WORD_W-1:0]  etype,
    input logic [WORD_W-1:0]  opc,
    input logic [WORD_W-1:0]  dur
  );
    logic [HDR_W-1:0] hdr;
    hdr = {da, sa, etype, opc, dur};
    return hdr[HDR_W-1 - 8*idx -: 8];
  endfunction

endpackage

// File: rtl/pause_byte_ctr.sv
module pause_byte_ctr #(
  parameter int COUNT = 18,
  parameter int IDX_W = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT-1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idx_q <= '0;
    else if (clr_i)                  idx_q <= '0;
    else if (adv_i && idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  // R6
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/pause_field_mux.sv
module pause_field_mux
  import pause_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEST_ADDR = 48'h0180_C200_0001,
  parameter logic [WORD_W-1:0] ETYPE     = 16'h8808,
  parameter logic [WORD_W-1:0] OPCODE    = 16'h0001,
  parameter int                IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [WORD_W-1:0] dur_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        byte_o
);

  logic [ADDR_W-1:0] sa_q;
  logic [WORD_W-1:0] dur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q  <= '0;
      dur_q <= '0;
    end else if (load_i) begin
      sa_q  <= sa_i;
      dur_q <= dur_i;
    end
  end

  always_comb begin
    byte_o = hdr_byte(int'(idx_i), DEST_ADDR, sa_q, ETYPE, OPCODE, dur_q);
  end

  // R9
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(sa_q) && $stable(dur_q)));

endmodule

// File: rtl/pause_ctrl_fsm.sv
module pause_ctrl_fsm
  import pause_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pause_req_i,
  input  logic         fdx_en_i,
  input  logic         stop_done_i,
  input  logic         adv_i,
  input  logic         last_i,
  output pause_state_t state_o,
  output logic         accept_o,
  output logic         gstop_req_o,
  output logic         stop_irq_o,
  output logic         sending_o,
  output logic         req_clr_o
);

  pause_state_t state_q, state_d;

  assign accept_o = (state_q == PS_IDLE) && pause_req_i && fdx_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:     if (accept_o)               state_d = PS_WAIT;
      PS_WAIT:     if (stop_done_i)            state_d = PS_ANNOUNCE;
      PS_ANNOUNCE:                             state_d = PS_SEND;
      PS_SEND:     if (adv_i && last_i)        state_d = PS_DONE;
      PS_DONE:                                 state_d = PS_IDLE;
      default:                                 state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  assign state_o     = state_q;
  assign gstop_req_o = (state_q == PS_WAIT) || (state_q == PS_ANNOUNCE) ||
                       (state_q == PS_SEND);
  assign stop_irq_o  = (state_q == PS_ANNOUNCE);
  assign sending_o   = (state_q == PS_SEND);
  assign req_clr_o   = (state_q == PS_DONE);

  // R3
  irq_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAIT && stop_done_i) |=> stop_irq_o);

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq_o |=> !stop_irq_o);

  // R7
  clr_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr_o |-> $past(adv_i && last_i));

  // R2
  no_fdx_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && !fdx_en_i) |=> !gstop_req_o);

  // R10
  idle_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE) |=> !stop_irq_o);

endmodule

// File: rtl/pause_tx_seq.sv
module pause_tx_seq
  import pause_seq_pkg::*;
#(
  parameter logic [47:0] DEST_ADDR = 48'h0180_C200_0001,
  parameter logic [15:0] ETYPE     = 16'h8808,
  parameter logic [15:0] OPCODE    = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pause_req_i,
  input  logic        fdx_en_i,
  input  logic        stop_done_i,
  input  logic [15:0] pause_dur_i,
  input  logic [47:0] station_addr_i,
  input  logic        byte_rdy_i,
  output logic        gstop_req_o,
  output logic        stop_irq_o,
  output logic [7:0]  tx_byte_o,
  output logic        tx_valid_o,
  output logic        tx_sof_o,
  output logic        tx_eof_o,
  output logic        req_clr_o
);

  localparam int IDX_W = $clog2(HDR_BYTES);

  pause_state_t     state;
  logic             accept;
  logic             sending;
  logic             byte_taken;
  logic             at_last;
  logic [IDX_W-1:0] byte_idx;

  assign byte_taken = sending && byte_rdy_i;

  pause_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pause_req_i (pause_req_i),
    .fdx_en_i    (fdx_en_i),
    .stop_done_i (stop_done_i),
    .adv_i       (byte_taken),
    .last_i      (at_last),
    .state_o     (state),
    .accept_o    (accept),
    .gstop_req_o (gstop_req_o),
    .stop_irq_o  (stop_irq_o),
    .sending_o   (sending),
    .req_clr_o   (req_clr_o)
  );

  pause_byte_ctr #(
    .COUNT (HDR_BYTES),
    .IDX_W (IDX_W)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!sending),
    .adv_i  (byte_taken),
    .idx_o  (byte_idx),
    .last_o (at_last)
  );

  pause_field_mux #(
    .DEST_ADDR (DEST_ADDR),
    .ETYPE     (ETYPE),
    .OPCODE    (OPCODE),
    .IDX_W     (IDX_W)
  ) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .sa_i   (station_addr_i),
    .dur_i  (pause_dur_i),
    .idx_i  (byte_idx),
    .byte_o (tx_byte_o)
  );

  assign tx_valid_o = sending;
  assign tx_sof_o   = sending && (byte_idx == '0);
  assign tx_eof_o   = sending && at_last;

  // R6
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !byte_rdy_i) |=>
      (tx_valid_o && $stable(tx_byte_o) && $stable(tx_sof_o) && $stable(tx_eof_o)));

  // R5
  sof_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sof_o) |-> $past(stop_irq_o));

  // R7
  eof_then_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eof_o && byte_rdy_i) |=> (req_clr_o && !gstop_req_o));

  // R3
  stream_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> gstop_req_o);

  // R5
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_o |-> (!tx_sof_o && !tx_eof_o));

endmodule

// File: tb/tb_pause_tx_seq.sv
module tb_pause_tx_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pause_req_i;
  logic        fdx_en_i;
  logic        stop_done_i;
  logic [15:0] pause_dur_i;
  logic [47:0] station_addr_i;
  logic        byte_rdy_i;
  logic        gstop_req_o;
  logic        stop_irq_o;
  logic [7:0]  tx_byte_o;
  logic        tx_valid_o;
  logic        tx_sof_o;
  logic        tx_eof_o;
  logic        req_clr_o;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pause_tx_seq dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pause_req_i    (pause_req_i),
    .fdx_en_i       (fdx_en_i),
    .stop_done_i    (stop_done_i),
    .pause_dur_i    (pause_dur_i),
    .station_addr_i (station_addr_i),
    .byte_rdy_i     (byte_rdy_i),
    .gstop_req_o    (gstop_req_o),
    .stop_irq_o     (stop_irq_o),
    .tx_byte_o      (tx_byte_o),
    .tx_valid_o     (tx_valid_o),
    .tx_sof_o       (tx_sof_o),
    .tx_eof_o       (tx_eof_o),
    .req_clr_o      (req_clr_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {gstop_req_o, stop_irq_o, tx_valid_o, tx_sof_o, tx_eof_o, req_clr_o};
  endfunction

  // Expected header built field by field from R4.
  function automatic logic [7:0] expect_byte(input int i, input logic [47:0] sa,
                                             input logic [15:0] dur);
    logic [7:0] da [6];
    da[0] = 8'h01; da[1] = 8'h80; da[2] = 8'hC2;
    da[3] = 8'h00; da[4] = 8'h00; da[5] = 8'h01;
    if (i < 6)       return da[i];
    else if (i < 12) return 8'((sa >> (8*(11-i))) & 48'hFF);
    else if (i == 12) return 8'h88;
    else if (i == 13) return 8'h08;
    else if (i == 14) return 8'h00;
    else if (i == 15) return 8'h01;
    else if (i == 16) return dur[15:8];
    else              return dur[7:0];
  endfunction

  task automatic test_reset();
    rst_n = 1'b0; pause_req_i = 0; fdx_en_i = 0; stop_done_i = 0;
    pause_dur_i = 16'h0; station_addr_i = 48'h0; byte_rdy_i = 0;
    repeat (3) @(negedge clk);
    chk(outs() == 6'b0, "R1 outputs during reset", 64'(outs()), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 6'b0, "R1 outputs after reset", 64'(outs()), 64'h0);
  endtask

  task automatic test_no_fdx();
    fdx_en_i = 0; pause_req_i = 1;
    repeat (4) @(negedge clk);
    chk(!gstop_req_o, "R2 no start without full duplex", 64'(gstop_req_o), 64'h0);
    chk(!tx_valid_o, "R2 no stream without full duplex", 64'(tx_valid_o), 64'h0);
    pause_req_i = 0;
    @(negedge clk);
  endtask

  task automatic test_idle_stop();
    stop_done_i = 1;
    @(negedge clk);
    stop_done_i = 0;
    chk(!stop_irq_o, "R10 idle stop_done gives no irq", 64'(stop_irq_o), 64'h0);
    @(negedge clk);
    chk(!stop_irq_o && !tx_valid_o, "R10 idle stop_done gives no stream",
        64'({stop_irq_o, tx_valid_o}), 64'h0);
  endtask

  task automatic run_frame(input logic [47:0] sa, input logic [15:0] dur,
                           input bit stall, input bit disturb);
    logic [47:0] sa0;
    logic [15:0] dur0;
    sa0 = sa; dur0 = dur;
    station_addr_i = sa; pause_dur_i = dur;
    fdx_en_i = 1; pause_req_i = 1;
    @(negedge clk);
    chk(gstop_req_o, "R2 stop request raised", 64'(gstop_req_o), 64'h1);
    if (disturb) begin
      station_addr_i = ~sa; pause_dur_i = ~dur;
    end
    for (int w = 0; w < 3; w++) begin
      if (disturb) pause_req_i = ~pause_req_i;
      @(negedge clk);
      chk(!tx_valid_o && !stop_irq_o, "R3 no bytes before stop",
          64'({tx_valid_o, stop_irq_o}), 64'h0);
      chk(gstop_req_o, "R8 stop request held while waiting", 64'(gstop_req_o), 64'h1);
    end
    pause_req_i = 1;
    stop_done_i = 1;
    @(negedge clk);
    stop_done_i = 0;
    chk(stop_irq_o && !tx_valid_o, "R3 irq pulse after stop",
        64'({stop_irq_o, tx_valid_o}), 64'h2);
    @(negedge clk);
    chk(!stop_irq_o, "R3 irq lasts one cycle", 64'(stop_irq_o), 64'h0);
    for (int i = 0; i < 18; i++) begin
      logic [7:0] e;
      e = expect_byte(i, sa0, dur0);
      chk(tx_valid_o, $sformatf("R3 byte %0d valid", i), 64'(tx_valid_o), 64'h1);
      chk(tx_byte_o == e, $sformatf("R4 byte %0d value", i), 64'(tx_byte_o), 64'(e));
      chk(tx_sof_o == (i == 0), $sformatf("R5 sof at byte %0d", i),
          64'(tx_sof_o), 64'(i == 0));
      chk(tx_eof_o == (i == 17), $sformatf("R5 eof at byte %0d", i),
          64'(tx_eof_o), 64'(i == 17));
      if (stall) begin
        byte_rdy_i = 0;
        @(negedge clk);
        chk(tx_valid_o && tx_byte_o == e, $sformatf("R6 byte %0d held", i),
            64'(tx_byte_o), 64'(e));
      end
      if (disturb && i == 5) pause_req_i = 0;
      if (disturb && i == 9) begin
        pause_req_i = 1; station_addr_i = 48'h0; pause_dur_i = 16'h0;
      end
      byte_rdy_i = 1;
      @(negedge clk);
      byte_rdy_i = 0;
    end
    chk(req_clr_o && !gstop_req_o, "R7 clear and stop drop together",
        64'({req_clr_o, gstop_req_o}), 64'h2);
    chk(!tx_valid_o, "R7 stream ended", 64'(tx_valid_o), 64'h0);
    pause_req_i = 0;
    @(negedge clk);
    chk(!req_clr_o && !gstop_req_o, "R7 clear lasts one cycle",
        64'({req_clr_o, gstop_req_o}), 64'h0);
    repeat (2) @(negedge clk);
    chk(outs() == 6'b0, "R8 no second frame", 64'(outs()), 64'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_no_fdx();
    test_idle_stop();
    run_frame(48'h0011_2233_4455, 16'hABCD, 1'b0, 1'b0);
    run_frame(48'hF0E1_D2C3_B4A5, 16'h0102, 1'b1, 1'b0);
    run_frame(48'h1357_9BDF_0246, 16'hFFFF, 1'b1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule